// File: doc/BRIEF.md
# Five-Area External Memory Bus Controller

This block connects an internal 32-bit request/response port to an external bus of asynchronous SRAM-style devices. The upper address bits pick one of five areas. Each area has its own active-low chip select, its own external data width (8, 16 or 32 bits) and its own read and write wait counts. A 32-bit internal access to a narrow area becomes a burst of two or four external cycles. The lower address bits step for each cycle, and the read word is assembled before the response is returned.

Between consecutive accesses the controller can hold off the next external cycle by 0 to 3 idle clocks. Five separate fields set this count, one for each kind of transition. An access to an address outside the five areas makes no external cycle and returns an error.

The controller is one state machine with five states. IDLE accepts a request. GAP inserts idle clocks. SETUP drives chip select with both strobes inactive. STROBE holds the read or write strobe. RESP returns the response. The transitions are:
- IDLE→RESP for an unmapped address.
- IDLE→GAP when the idle count is nonzero.
- IDLE→SETUP otherwise.
- GAP→SETUP when the idle count runs out.
- SETUP→STROBE always.
- STROBE→SETUP when the wait count runs out and more beats remain.
- STROBE→RESP after the last beat.
- RESP→IDLE always.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The six bits `req_addr[31:26]` form the area index. Values 0 to 4 select an area. `ext_cs_n[i]` goes low only during the SETUP and STROBE clocks of an access to area i, and at most one chip select is low at any time.
- R2: The width code of an area is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. For area 0, codes 2 and 3 are stored as 16 bits.
- R3: Each external beat is one setup clock (chip select low, both strobes high), then 1+W clocks with the strobe low. W is the area's read wait for reads and its write wait for writes, each 0 to 7. The read and write strobes are never low together.
- R4: A request makes 4, 2 or 1 beats for 8-, 16- or 32-bit areas. For beat b, `ext_addr` is the word-aligned offset with its low two bits set to b (8-bit), to {b,0} (16-bit) or to 00 (32-bit). Narrow data uses the low byte lanes.
- R5: Read data is assembled little-endian. Beat b fills byte b (8-bit) or halfword b (16-bit) of `rsp_rdata`.
- R6: On writes, beat b drives the matching byte or halfword of `req_wdata` on the low lanes of `ext_dout`. It drives the matching active-low byte enables on `ext_be_n`, and unused lanes show data 0 and enable 1.
- R7: The idle count is chosen from the previous mapped access P and the current access C:
  - P was a write: the after-write field.
  - P was a read and C is a write: the read-write same-area field or the read-write other-area field.
  - P was a read and C is a read: the read-read same-area field or the read-read other-area field.
- R8: The first access after reset gets no idle clocks. An unmapped access does not change the history used by R7.
- R9: An unmapped access makes no chip select or strobe. It returns `rsp_err`=1 and `rsp_rdata`=0, with `rsp_valid` one clock after acceptance.
- R10: `req_ready` is high only in IDLE. `rsp_valid` is a single-clock pulse, G + B×(2+W) + 1 clocks after the accepting edge, where G is the idle count and B is the beat count. Writes return `rsp_rdata`=0.
- R11: Configuration loads at the clock edge when `cfg_we` is high.
  - `cfg_sel` 0 to 4 selects an area word: bits [1:0] width code, [4:2] read wait, [7:5] write wait.
  - `cfg_sel` 5 selects the idle word: [1:0] read-write same, [3:2] read-write other, [5:4] read-read same, [7:6] read-read other, [9:8] after write.
- R12: After reset every area is 16 bits wide with read and write waits of 7, and all five idle fields are 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (0-4 area, 5 idle) |
| cfg_wdata | input | 10 | Configuration data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Request byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, active high |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Address hit no area |
| ext_cs_n | output | 5 | Active-low chip select per area |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 1 | Active-low write strobe |
| ext_addr | output | 26 | External address within the area |
| ext_dout | output | 32 | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_be_n | output | 4 | Active-low byte lane enables |
| ext_din | input | 32 | External read data |

## Verification
The bench builds the block with its defaults: five areas, each 64 Mbytes, with a 32-bit address. Eight rounds sweep every read and write wait value from 0 to 7, with 8-, 16- and 32-bit areas active at the same time. The rounds also rotate the five idle fields, so every transition case is paired with several idle counts. The coercion of area 0, the reset defaults and the handling of history around unmapped addresses are reached directly. Each check compares latency, strobe and setup counts, and the data of every beat against arithmetic expectations.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int CFG_W  = 10;

    typedef enum logic [1:0] {
        BW8  = 2'd0,
        BW16 = 2'd1,
        BW32 = 2'd2
    } bus_width_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_SETUP,
        S_STROBE,
        S_RESP
    } ebc_state_e;

    typedef struct packed {
        logic [2:0] wr_wait;
        logic [2:0] rd_wait;
        bus_width_e width;
    } area_cfg_t;

    typedef struct packed {
        logic [1:0] after_wr;
        logic [1:0] rr_other;
        logic [1:0] rr_same;
        logic [1:0] rw_other;
        logic [1:0] rw_same;
    } idle_cfg_t;
endpackage

// File: rtl/ebc_area_dec.sv
module ebc_area_dec #(
    parameter int ADDR_W     = 32,
    parameter int AREA_SHIFT = 26,
    parameter int N_AREAS    = 5,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int UPPER_W = ADDR_W - AREA_SHIFT;

    logic [UPPER_W-1:0] upper;

    always_comb begin
        upper = addr[ADDR_W-1:AREA_SHIFT];
        hit   = (upper < UPPER_W'(N_AREAS));
        idx   = upper[IDX_W-1:0];
    end
endmodule

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
    import ebc_pkg::*;
#(
    parameter int N_AREAS = 5,
    parameter int SEL_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output area_cfg_t [N_AREAS-1:0]       area_cfg,
    output idle_cfg_t                     idle_cfg
);
    function automatic bus_width_e decode_width(input logic [1:0] code, input logic wide_ok);
        if (code == 2'd0)      return BW8;
        else if (code == 2'd1) return BW16;
        else if (wide_ok)      return BW32;
        else                   return BW16;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AREAS; i++) begin
                area_cfg[i] <= '{wr_wait: 3'd7, rd_wait: 3'd7, width: BW16};
            end
            idle_cfg <= '{after_wr: 2'd3, rr_other: 2'd3, rr_same: 2'd3,
                          rw_other: 2'd3, rw_same: 2'd3};
        end else if (cfg_we) begin
            for (int i = 0; i < N_AREAS; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    area_cfg[i] <= '{wr_wait: cfg_wdata[7:5],
                                     rd_wait: cfg_wdata[4:2],
                                     width:   decode_width(cfg_wdata[1:0], i != 0)};
                end
            end
            if (cfg_sel == SEL_W'(N_AREAS)) begin
                idle_cfg <= idle_cfg_t'(cfg_wdata);
            end
        end
    end

    // R2
    area0_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        area_cfg[0].width != BW32);
endmodule

// File: rtl/ebc_gap_sel.sv
module ebc_gap_sel
    import ebc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             have_prev,
    input  logic             prev_we,
    input  logic [IDX_W-1:0] prev_idx,
    input  logic             cur_we,
    input  logic [IDX_W-1:0] cur_idx,
    input  idle_cfg_t        idle_cfg,
    output logic [1:0]       gap
);
    logic same;

    always_comb begin
        same = (prev_idx == cur_idx);
        if (!have_prev)   gap = 2'd0;
        else if (prev_we) gap = idle_cfg.after_wr;
        else if (cur_we)  gap = same ? idle_cfg.rw_same : idle_cfg.rw_other;
        else              gap = same ? idle_cfg.rr_same : idle_cfg.rr_other;
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int AREA_SHIFT = 26,
    parameter  int N_AREAS    = 5,
    localparam int SEL_W      = $clog2(N_AREAS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_we,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [BE_W-1:0]       req_be,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_err,
    output logic [N_AREAS-1:0]    ext_cs_n,
    output logic                  ext_rd_n,
    output logic                  ext_we_n,
    output logic [AREA_SHIFT-1:0] ext_addr,
    output logic [DATA_W-1:0]     ext_dout,
    output logic                  ext_doe,
    output logic [BE_W-1:0]       ext_be_n,
    input  logic [DATA_W-1:0]     ext_din
);
    localparam int IDX_W = SEL_W;

    area_cfg_t [N_AREAS-1:0] area_cfg;
    idle_cfg_t               idle_cfg;
    logic                    dec_hit;
    logic [IDX_W-1:0]        dec_idx;
    logic [1:0]              gap;

    ebc_state_e               state;
    logic [2:0]               cnt;
    logic [1:0]               beat;
    logic [AREA_SHIFT-1:2]    r_off;
    logic                     r_we, r_hit;
    logic [IDX_W-1:0]         r_idx;
    logic [DATA_W-1:0]        r_wdata, rdbuf;
    logic [BE_W-1:0]          r_be;
    logic                     have_prev, prev_we;
    logic [IDX_W-1:0]         prev_idx;
    area_cfg_t                cur;
    logic [1:0]               last_beat;
    logic                     active;
    logic                     unused_lsb;

    assign unused_lsb = ^req_addr[1:0];

    ebc_cfg_regs #(.N_AREAS(N_AREAS), .SEL_W(SEL_W)) u_cfg (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
        .area_cfg(area_cfg), .idle_cfg(idle_cfg)
    );

    ebc_area_dec #(.ADDR_W(ADDR_W), .AREA_SHIFT(AREA_SHIFT),
                   .N_AREAS(N_AREAS), .IDX_W(IDX_W)) u_dec (
        .addr(req_addr), .hit(dec_hit), .idx(dec_idx)
    );

    ebc_gap_sel #(.IDX_W(IDX_W)) u_gap (
        .have_prev, .prev_we, .prev_idx,
        .cur_we(req_we), .cur_idx(dec_idx), .idle_cfg, .gap
    );

    always_comb begin
        cur = area_cfg[r_hit ? r_idx : '0];
        unique case (cur.width)
            BW8:     last_beat = 2'd3;
            BW16:    last_beat = 2'd1;
            default: last_beat = 2'd0;
        endcase
    end

    // State register and access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            beat      <= '0;
            r_off     <= '0;
            r_we      <= 1'b0;
            r_hit     <= 1'b0;
            r_idx     <= '0;
            r_wdata   <= '0;
            r_be      <= '0;
            rdbuf     <= '0;
            have_prev <= 1'b0;
            prev_we   <= 1'b0;
            prev_idx  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    r_off   <= req_addr[AREA_SHIFT-1:2];
                    r_we    <= req_we;
                    r_hit   <= dec_hit;
                    r_idx   <= dec_idx;
                    r_wdata <= req_wdata;
                    r_be    <= req_be;
                    rdbuf   <= '0;
                    beat    <= '0;
                    if (!dec_hit) begin
                        state <= S_RESP;
                    end else if (gap != 2'd0) begin
                        state <= S_GAP;
                        cnt   <= {1'b0, gap - 2'd1};
                    end else begin
                        state <= S_SETUP;
                    end
                end
                S_GAP: begin
                    if (cnt == '0) state <= S_SETUP;
                    else           cnt   <= cnt - 3'd1;
                end
                S_SETUP: begin
                    state <= S_STROBE;
                    cnt   <= r_we ? cur.wr_wait : cur.rd_wait;
                end
                S_STROBE: begin
                    if (cnt == '0) begin
                        if (!r_we) begin
                            unique case (cur.width)
                                BW8:     rdbuf[{beat, 3'b000} +: 8]   <= ext_din[7:0];
                                BW16:    rdbuf[{beat[0], 4'b0000} +: 16] <= ext_din[15:0];
                                default: rdbuf <= ext_din;
                            endcase
                        end
                        if (beat == last_beat) begin
                            state <= S_RESP;
                        end else begin
                            beat  <= beat + 2'd1;
                            state <= S_SETUP;
                        end
                    end else begin
                        cnt <= cnt - 3'd1;
                    end
                end
                S_RESP: begin
                    state <= S_IDLE;
                    if (r_hit) begin
                        have_prev <= 1'b1;
                        prev_we   <= r_we;
                        prev_idx  <= r_idx;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign active = (state == S_SETUP) || (state == S_STROBE);

    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        assign ext_cs_n[g] = !(active && (r_idx == IDX_W'(g)));
    end

    // Output decode
    always_comb begin
        req_ready = (state == S_IDLE);
        rsp_valid = (state == S_RESP);
        rsp_err   = !r_hit;
        rsp_rdata = (r_hit && !r_we) ? rdbuf : '0;
        ext_rd_n  = !((state == S_STROBE) && !r_we);
        ext_we_n  = !((state == S_STROBE) && r_we);
        ext_doe   = active && r_we;
        unique case (cur.width)
            BW8: begin
                ext_addr = {r_off, beat};
                ext_dout = {24'd0, r_wdata[{beat, 3'b000} +: 8]};
                ext_be_n = {3'b111, ~r_be[beat]};
            end
            BW16: begin
                ext_addr = {r_off, beat[0], 1'b0};
                ext_dout = {16'd0, r_wdata[{beat[0], 4'b0000} +: 16]};
                ext_be_n = {2'b11, ~r_be[{beat[0], 1'b0} +: 2]};
            end
            default: begin
                ext_addr = {r_off, 2'b00};
                ext_dout = r_wdata;
                ext_be_n = ~r_be;
            end
        endcase
    end

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));
    // R1
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_we_n) |-> (ext_cs_n != '1));
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_we_n));
    // R3
    rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_rd_n) |-> ($past(ext_cs_n) != '1));
    // R3
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_we_n) |-> ($past(ext_cs_n) != '1));
    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [9:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [4:0]  ext_cs_n;
    logic        ext_rd_n, ext_we_n, ext_doe;
    logic [25:0] ext_addr;
    logic [31:0] ext_dout;
    logic [3:0]  ext_be_n;
    logic [31:0] ext_din;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_bytes[5];
    int m_rw[5];
    int m_ww[5];
    int m_idle[5];   // 0 rw same, 1 rw other, 2 rr same, 3 rr other, 4 after write
    bit h_prev = 1'b0;
    bit h_we = 1'b0;
    int h_area = 0;

    ext_bus_ctrl u0 (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
        .req_valid, .req_ready, .req_addr, .req_we, .req_wdata, .req_be,
        .rsp_valid, .rsp_rdata, .rsp_err,
        .ext_cs_n, .ext_rd_n, .ext_we_n, .ext_addr, .ext_dout, .ext_doe,
        .ext_be_n, .ext_din
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] dbyte(input logic [25:0] a, input int lane, input int area);
        return 8'(int'(a[7:0]) * 7 + int'(a[15:8]) + lane * 53 + area * 75);
    endfunction

    // External memory model: data depends on address, lane and selected area
    always_comb begin
        int act;
        act = 0;
        for (int i = 0; i < 5; i++) if (!ext_cs_n[i]) act = i;
        for (int l = 0; l < 4; l++) ext_din[8*l +: 8] = dbyte(ext_addr, l, act);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_area(input int area, input int code, input int rw, input int ww);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = 3'(area);
        cfg_wdata = {2'b00, 3'(ww), 3'(rw), 2'(code)};
        @(negedge clk);
        cfg_we = 1'b0;
        m_bytes[area] = (code == 0) ? 1 : (code == 1) ? 2 : ((area == 0) ? 2 : 4);
        m_rw[area] = rw;
        m_ww[area] = ww;
    endtask

    task automatic cfg_idle(input int rws, input int rwo, input int rrs, input int rro, input int aw);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = 3'd5;
        cfg_wdata = {2'(aw), 2'(rro), 2'(rrs), 2'(rwo), 2'(rws)};
        @(negedge clk);
        cfg_we = 1'b0;
        m_idle[0] = rws; m_idle[1] = rwo; m_idle[2] = rrs; m_idle[3] = rro; m_idle[4] = aw;
    endtask

    task automatic access(input bit we, input int area, input logic [25:0] off_in,
                          input logic [31:0] wd, input logic [3:0] be, input string tag);
        bit mapped;
        int nb, w, gap, explat, n, strobes, setups, csbad, k;
        bit prev_we_hi, got;
        logic [25:0] off;
        logic [25:0] cap_addr[4];
        logic [31:0] cap_dout[4];
        logic [3:0]  cap_be[4];
        logic [31:0] rd, exp_rd;
        logic        err;
        mapped = (area < 5);
        off = {off_in[25:2], 2'b00};
        nb = 1; w = 0; gap = 0;
        if (mapped) begin
            nb = 4 / m_bytes[area];
            w = we ? m_ww[area] : m_rw[area];
            if (h_prev) begin
                if (h_we)     gap = m_idle[4];
                else if (we)  gap = (h_area == area) ? m_idle[0] : m_idle[1];
                else          gap = (h_area == area) ? m_idle[2] : m_idle[3];
            end
            explat = gap + nb * (2 + w) + 1;
        end else begin
            explat = 1;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_we = we;
        req_addr = {6'(area), off};
        req_wdata = wd;
        req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        n = 0; strobes = 0; setups = 0; csbad = 0; k = 0; prev_we_hi = 1'b1; got = 1'b0;
        rd = '0; err = 1'b0;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (!ext_rd_n || !ext_we_n) strobes++;
            if (ext_cs_n != 5'h1f && ext_rd_n && ext_we_n) setups++;
            if (mapped) begin
                if ((ext_cs_n | 5'(1 << area)) != 5'h1f) csbad++;
            end else if (ext_cs_n != 5'h1f) csbad++;
            if (!ext_we_n && prev_we_hi) begin
                if (k < 4) begin
                    cap_addr[k] = ext_addr;
                    cap_dout[k] = ext_dout;
                    cap_be[k] = ext_be_n;
                end
                k++;
            end
            prev_we_hi = ext_we_n;
            if (rsp_valid) begin
                got = 1'b1;
                rd = rsp_rdata;
                err = rsp_err;
                break;
            end
        end
        chk(got, tag, "response seen", longint'(got), 1);
        chk(n == explat, tag, "latency", n, explat);
        chk(csbad == 0, "R1", "wrong chip select clocks", csbad, 0);
        if (!mapped) begin
            chk(err == 1'b1, "R9", "err flag", err, 1);
            chk(rd == '0, "R9", "rdata", rd, 0);
            chk(strobes == 0 && setups == 0, "R9", "external activity", strobes + setups, 0);
        end else begin
            chk(err == 1'b0, "R10", "err flag", err, 0);
            chk(strobes == nb * (1 + w), "R3", "strobe clocks", strobes, nb * (1 + w));
            chk(setups == nb, "R3", "setup clocks", setups, nb);
            if (we) begin
                chk(k == nb, "R4", "write beats", k, nb);
                chk(rd == '0, "R10", "write rdata", rd, 0);
                for (int b = 0; b < nb && b < k; b++) begin
                    logic [25:0] ea;
                    logic [31:0] ed;
                    logic [3:0]  eb;
                    if (nb == 4) begin
                        ea = {off[25:2], 2'(b)};
                        ed = {24'd0, wd[8*b +: 8]};
                        eb = {3'b111, ~be[b]};
                    end else if (nb == 2) begin
                        ea = {off[25:2], 1'(b), 1'b0};
                        ed = {16'd0, wd[16*b +: 16]};
                        eb = {2'b11, ~be[2*b +: 2]};
                    end else begin
                        ea = off;
                        ed = wd;
                        eb = ~be;
                    end
                    chk(cap_addr[b] == ea, "R4", "beat address", cap_addr[b], ea);
                    chk(cap_dout[b] == ed, "R6", "beat data", cap_dout[b], ed);
                    chk(cap_be[b] == eb, "R6", "beat byte enables", cap_be[b], eb);
                end
            end else begin
                exp_rd = '0;
                for (int b = 0; b < nb; b++) begin
                    if (nb == 4) begin
                        exp_rd[8*b +: 8] = dbyte({off[25:2], 2'(b)}, 0, area);
                    end else if (nb == 2) begin
                        exp_rd[16*b +: 16] = {dbyte({off[25:2], 1'(b), 1'b0}, 1, area),
                                              dbyte({off[25:2], 1'(b), 1'b0}, 0, area)};
                    end else begin
                        for (int l = 0; l < 4; l++) exp_rd[8*l +: 8] = dbyte(off, l, area);
                    end
                end
                chk(rd == exp_rd, "R5", "read data", rd, exp_rd);
            end
            h_prev = 1'b1;
            h_we = we;
            h_area = area;
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            m_bytes[i] = 2; m_rw[i] = 7; m_ww[i] = 7; m_idle[i] = 3;
        end
        repeat (3) @(negedge clk);
        // Reset state of the outputs
        chk(req_ready == 1'b1, "R10", "ready at reset", req_ready, 1);
        chk(ext_cs_n == 5'h1f, "R1", "cs at reset", ext_cs_n, 5'h1f);
        chk(ext_rd_n && ext_we_n, "R3", "strobes at reset", {ext_rd_n, ext_we_n}, 3);
        chk(rsp_valid == 1'b0, "R10", "rsp at reset", rsp_valid, 0);
        rst_n = 1'b1;
        // R12 defaults and R8 first access: no gap, then rr same gap of 3
        access(1'b0, 0, 26'h0001230, '0, 4'hf, "R12");
        access(1'b0, 0, 26'h0001234, '0, 4'hf, "R12");
        access(1'b1, 3, 26'h0000040, 32'hcafe_f00d, 4'b1011, "R12");
        // R2 area 0 refuses 32-bit width
        cfg_area(0, 2, 1, 2);
        access(1'b0, 0, 26'h0000100, '0, 4'hf, "R2");
        access(1'b1, 0, 26'h0000104, 32'h1122_3344, 4'b0110, "R2");
        cfg_area(0, 3, 0, 0);
        access(1'b0, 0, 26'h0000108, '0, 4'hf, "R2");
        // R8 unmapped access between two reads leaves history alone; R9 result
        cfg_idle(1, 2, 3, 0, 1);
        access(1'b0, 0, 26'h0000200, '0, 4'hf, "R8");
        access(1'b0, 5, 26'h0000204, '0, 4'hf, "R9");
        access(1'b1, 63, 26'h0000208, 32'hffff_ffff, 4'hf, "R9");
        access(1'b0, 0, 26'h000020c, '0, 4'hf, "R8");
        // R7 / R11 sweep over wait counts, widths and idle fields
        for (int w = 0; w < 8; w++) begin
            cfg_area(1, 0, w, 7 - w);
            cfg_area(2, 2, w, w);
            cfg_area(3, 1, 7 - w, w);
            cfg_area(4, 3, 0, w);
            cfg_idle(w % 4, (w + 1) % 4, (w + 2) % 4, (w + 3) % 4, 3 - (w % 4));
            access(1'b0, 1, 26'(32'h10 * w + 32'h3000), '0, 4'hf, "R7");
            access(1'b1, 1, 26'(32'h10 * w + 32'h3004), 32'h0102_0304 * (w + 1), 4'(w + 5), "R7");
            access(1'b0, 1, 26'(32'h10 * w + 32'h3008), '0, 4'hf, "R7");
            access(1'b0, 2, 26'(32'h20 * w + 32'h4000), '0, 4'hf, "R7");
            access(1'b1, 2, 26'(32'h20 * w + 32'h4004), 32'hdead_0000 + 32'(w), 4'(w), "R7");
            access(1'b1, 3, 26'(32'h40 * w + 32'h5000), 32'h5a5a_a5a5 ^ 32'(w), 4'(15 - w), "R7");
            access(1'b0, 3, 26'(32'h40 * w + 32'h5004), '0, 4'hf, "R7");
            access(1'b0, 3, 26'(32'h40 * w + 32'h5008), '0, 4'hf, "R7");
            access(1'b1, 4, 26'(32'h80 * w + 32'h6000), 32'h7654_3210 + 32'(w), 4'hf, "R11");
            access(1'b0, 4, 26'(32'h80 * w + 32'h6004), '0, 4'hf, "R11");
            access(1'b0, 0, 26'(32'h08 * w + 32'h7000), '0, 4'hf, "R7");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule